// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the power-up ritual and the periodic refresh of an asynchronous dynamic RAM. It uses the column-strobe-first refresh ordering, so the device's internal row counter supplies the rows and no address is driven. After reset the sequencer stays quiet for a programmable pause. It then runs a fixed number of wake-up strobe cycles on its own and raises `ready`, which tells the access controller that normal traffic may begin.

In normal operation an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. While the sequencer owes a refresh and its strobe engine is idle, it raises `ref_req`. The access controller answers with `ref_gnt` once its own access has finished. The handshake follows request/grant rules. `ref_req` stays high until a clock edge samples it together with `ref_gnt`. That edge starts one refresh, and from then on `bus_own` switches the external strobe multiplexer to this block. The controller may hold `ref_gnt` low for as long as it needs; that is the back-pressure. A grant given while `ref_req` is low does nothing.

Up to `MAX_DEBT` owed refreshes are queued. If one more falls due while the queue is full, the refresh period counts as violated. The sequencer then sets a sticky `debt_ovf` flag and drops `ready`. It requests the bus, and once granted it repeats the whole wake-up series before raising `ready` again.

Top module: `dram_refresh_seq`

## Requirements
- R1: Reset state: while `rst` is high, `row_stb_n`=1, `col_stb_n`=2'b11, `ready`=0, `ref_req`=0, `debt_ovf`=0 and `bus_own`=1.
- R2: After `rst` falls, the strobes stay inactive for exactly `PAUSE_CYC` clock edges. The column strobes first go low after edge `PAUSE_CYC+1`.
- R3: The init series consists of exactly `WAKE_CNT` refresh cycles, with `ref_req` held low throughout. `ready` first reads 1 after edge `PAUSE_CYC+1+WAKE_CNT*(T_CSR+T_RAS+T_RP+1)`.
- R4: Every refresh drives both column strobes low for exactly `T_CSR` clocks before the row strobe falls. They are still low on the cycle the row strobe falls.
- R5: After the row strobe falls, the column strobes stay low for exactly `T_CHR` clocks. They then rise while the row strobe is still low.
- R6: The row strobe stays low for exactly `T_RAS` clocks per refresh. Consecutive low pulses are separated by at least `T_RP+T_CSR` high clocks.
- R7: Once `ready` rises, one refresh becomes owed every `INTERVAL_CYC` clocks. `ref_req` first reads 1 exactly `INTERVAL_CYC` clocks after `ready`.
- R8: `ref_req` stays high until it is sampled with `ref_gnt`=1. That edge starts a refresh: after it, `bus_own`=1, `col_stb_n`=2'b00 and `ref_req`=0. A grant while `ref_req`=0 causes no strobe activity.
- R9: Owed refreshes (up to `MAX_DEBT`) are served one per grant. `ref_req` rises again as soon as a refresh ends while any remain owed.
- R10: When a refresh falls due with `MAX_DEBT` already owed, the sequencer sets `debt_ovf`, which stays set until reset, clears `ready` and raises `ref_req`. After the grant it runs `WAKE_CNT` refresh cycles, and `ready` returns `1+WAKE_CNT*(T_CSR+T_RAS+T_RP+1)` edges after the grant edge.
- R11: The two column strobe bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing parameters count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request for a refresh or a re-wake series |
| ready | output | 1 | Device initialised and refresh debt under control |
| bus_own | output | 1 | Select for the strobe multiplexer: this block drives the strobes |
| row_stb_n | output | 1 | Row strobe to the device, active low |
| col_stb_n | output | 2 | Column strobes (upper, lower byte), active low |
| debt_ovf | output | 1 | Sticky flag: refresh debt exceeded its limit |

## Verification
The bench builds the block with a 10-clock pause, 3 wake-up cycles, a 40-clock interval, a debt limit of 2, and strobe timings of 2/2/5/3 clocks. With these values a refresh lasts 10 clocks plus one idle clock. The whole life cycle then fits in a few hundred clocks: pause, wake series, first request, held-off grants, a queue filled to its limit and drained back to back, an overflow, and the repeated wake series. Every expected edge position is computed from those parameters. A free-running strobe monitor measures each setup, hold, pulse and gap length on every refresh the block issues.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HOLD, PH_ACT, PH_PRE} phase_t;
  typedef enum logic [1:0] {M_PAUSE, M_WAKE, M_RUN, M_REWAIT} mode_t;
endpackage

// File: rtl/dref_strobe.sv
module dref_strobe
  import dref_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       row_n,
  output logic [1:0] col_n
);
  localparam int T_ACT = T_RAS - T_CHR;
  localparam int M1    = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int M2    = (T_ACT > T_RP) ? T_ACT : T_RP;
  localparam int TMAX  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(TMAX + 1);

  phase_t          ph, nxt;
  logic [CW-1:0]   cnt;

  function automatic logic [CW-1:0] last_of(phase_t p);
    case (p)
      PH_SETUP: return CW'(T_CSR - 1);
      PH_HOLD:  return CW'(T_CHR - 1);
      PH_ACT:   return CW'(T_ACT - 1);
      PH_PRE:   return CW'(T_RP - 1);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    case (ph)
      PH_SETUP: nxt = PH_HOLD;
      PH_HOLD:  nxt = PH_ACT;
      PH_ACT:   nxt = PH_PRE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        ph  <= PH_SETUP;
        cnt <= last_of(PH_SETUP);
      end
    end else if (cnt == '0) begin
      ph  <= nxt;
      cnt <= last_of(nxt);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_PRE) && (cnt == '0);
  assign col_n = {2{!((ph == PH_SETUP) || (ph == PH_HOLD))}};
  assign row_n = !((ph == PH_HOLD) || (ph == PH_ACT));

  AST_COL_LEADS_ROW: assert property (@(posedge clk) disable iff (rst)
    $fell(row_n) |-> (col_n == 2'b00 && $past(col_n) == 2'b00)); // R4
  AST_ROW_ENDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(row_n) |-> (col_n == 2'b11)); // R5
endmodule

// File: rtl/dref_tick.sv
module dref_tick #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dref_debt.sv
module dref_debt #(
  parameter int MAX_DEBT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic owed,
  output logic full
);
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic [DW-1:0] debt;

  assign owed = (debt != '0);
  assign full = (debt == DW'(MAX_DEBT));

  always_ff @(posedge clk) begin
    if (rst || clr)                debt <= '0;
    else if (inc && !dec && !full) debt <= debt + 1'b1;
    else if (dec && !inc)          debt <= debt - 1'b1;
  end

  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (rst)
    debt <= DW'(MAX_DEBT)); // R9
  AST_DEC_OWED: assert property (@(posedge clk) disable iff (rst)
    dec |-> owed); // R9
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 4,
  parameter int T_RP         = 3,
  parameter int MAX_DEBT     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       ready,
  output logic       bus_own,
  output logic       row_stb_n,
  output logic [1:0] col_stb_n,
  output logic       debt_ovf
);
  localparam int PW = $clog2(PAUSE_CYC);
  localparam int WW = $clog2(WAKE_CNT + 1);

  mode_t         mode;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic          eng_busy, eng_done, eng_idle, start;
  logic          tick, owed, full, dec, ovf_evt;

  assign eng_idle = !eng_busy;
  assign dec      = (mode == M_RUN) && eng_idle && owed && ref_gnt;
  assign start    = dec || ((mode == M_WAKE) && eng_idle && (wcnt != WW'(WAKE_CNT)));
  assign ovf_evt  = tick && !dec && full;
  assign ref_req  = eng_idle && (((mode == M_RUN) && owed) || (mode == M_REWAIT));
  assign ready    = (mode == M_RUN);
  assign bus_own  = (mode == M_PAUSE) || (mode == M_WAKE) || eng_busy;

  dref_strobe #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
    .clk(clk), .rst(rst), .start(start), .busy(eng_busy), .done(eng_done),
    .row_n(row_stb_n), .col_n(col_stb_n));

  dref_tick #(.INTERVAL(INTERVAL_CYC)) u_tick (
    .clk(clk), .rst(rst), .en(mode == M_RUN), .tick(tick));

  dref_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst(rst), .clr((mode != M_RUN) || ovf_evt), .inc(tick), .dec(dec),
    .owed(owed), .full(full));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_PAUSE;
      pcnt     <= '0;
      wcnt     <= '0;
      debt_ovf <= 1'b0;
    end else begin
      case (mode)
        M_PAUSE: begin
          if (pcnt == PW'(PAUSE_CYC - 1)) begin
            mode <= M_WAKE;
            wcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        M_WAKE: begin
          if (eng_done) wcnt <= wcnt + 1'b1;
          if (eng_idle && wcnt == WW'(WAKE_CNT)) mode <= M_RUN;
        end
        M_RUN: begin
          if (ovf_evt) begin
            mode     <= M_REWAIT;
            debt_ovf <= 1'b1;
          end
        end
        default: begin
          if (ref_gnt && eng_idle) begin
            mode <= M_WAKE;
            wcnt <= '0;
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    debt_ovf |=> debt_ovf); // R10
  AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (wcnt == WW'(WAKE_CNT))); // R3
  AST_COL_PAIR: assert property (@(posedge clk) disable iff (rst)
    col_stb_n[0] == col_stb_n[1]); // R11
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int CLK_PER  = 10;
  localparam int PAUSE    = 10;
  localparam int WAKE     = 3;
  localparam int INTV     = 40;
  localparam int TCSR     = 2;
  localparam int TCHR     = 2;
  localparam int TRAS     = 5;
  localparam int TRP      = 3;
  localparam int MAXD     = 2;
  localparam int CYC      = TCSR + TRAS + TRP + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_gnt = 1'b0;
  logic       ref_req, ready, bus_own, row_stb_n, debt_ovf;
  logic [1:0] col_stb_n;

  int nchk = 0, nfail = 0, scnt = 0, cbr = 0;
  bit finished = 0;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .T_CSR(TCSR),
    .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP), .MAX_DEBT(MAXD)
  ) uut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready),
    .bus_own(bus_own), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .debt_ovf(debt_ovf));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, scnt);
    end
  endtask

  always @(posedge clk) begin
    if (rst) scnt <= 0;
    else     scnt <= scnt + 1;
  end

  // strobe waveform monitor, samples 1 time unit after the falling clock edge
  bit pr_row = 1, pr_cl = 0;
  int hi_run = 0, lo_run = 0, setup_run = 0, hold_run = 0;
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      bit cl;
      cl = (col_stb_n == 2'b00);
      chk(col_stb_n[0] == col_stb_n[1], "R11 column strobes equal", col_stb_n[1], col_stb_n[0]);
      if (pr_row && !row_stb_n) begin
        chk(cl, "R4 column low at row fall", cl, 1);
        chk(setup_run == TCSR, "R4 setup length", setup_run, TCSR);
        chk(hi_run >= TRP + TCSR, "R6 row high gap", hi_run, TRP + TCSR);
        cbr++;
        lo_run = 0;
        hold_run = 0;
      end
      if (!pr_row && row_stb_n) begin
        chk(lo_run == TRAS, "R6 row low width", lo_run, TRAS);
        hi_run = 0;
      end
      if (pr_cl && !cl && !row_stb_n)
        chk(hold_run == TCHR, "R5 column hold length", hold_run, TCHR);
      if (pr_cl && !cl)
        chk(!row_stb_n, "R5 column rises under low row", row_stb_n, 0);
      if (row_stb_n) hi_run++; else lo_run++;
      if (cl && row_stb_n) setup_run++; else setup_run = 0;
      if (cl && !row_stb_n) hold_run++;
      pr_row = row_stb_n;
      pr_cl  = cl;
    end
  end

  task automatic wait_idx(input int n);
    while (scnt < n) @(negedge clk);
  endtask

  task automatic grant_once();
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", scnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n, r, g, c0, reqseen;
    repeat (3) @(negedge clk);
    // R1
    chk(row_stb_n == 1'b1, "R1 row strobe in reset", row_stb_n, 1);
    chk(col_stb_n == 2'b11, "R1 column strobes in reset", col_stb_n, 3);
    chk(!ready && !ref_req && !debt_ovf, "R1 flags in reset", {ready, ref_req, debt_ovf}, 0);
    chk(bus_own, "R1 ownership in reset", bus_own, 1);
    rst = 1'b0;

    // R2: quiet pause
    n = 0;
    @(negedge clk);
    while (col_stb_n == 2'b11 && n < 1000) begin n++; @(negedge clk); end
    chk(n == PAUSE, "R2 pause length", n, PAUSE);
    chk(scnt == PAUSE + 1, "R2 first column fall edge", scnt, PAUSE + 1);

    // R3: wake series then ready
    reqseen = 0;
    while (!ready && scnt < 1000) begin
      if (ref_req) reqseen = 1;
      @(negedge clk);
    end
    r = scnt;
    chk(r == PAUSE + 1 + WAKE * CYC, "R3 ready edge", r, PAUSE + 1 + WAKE * CYC);
    chk(cbr == WAKE, "R3 wake cycle count", cbr, WAKE);
    chk(reqseen == 0, "R3 no request during init", reqseen, 0);

    // R7: first request after one interval
    while (!ref_req && scnt < r + 1000) @(negedge clk);
    chk(scnt == r + INTV, "R7 first request edge", scnt, r + INTV);

    // R8: request held while grant withheld
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ref_req && col_stb_n == 2'b11, "R8 request held without grant", ref_req, 1);
    end
    c0 = cbr;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(!ref_req, "R8 request drops on grant", ref_req, 0);
    chk(bus_own, "R8 ownership after grant", bus_own, 1);
    chk(col_stb_n == 2'b00, "R8 refresh begins after grant", col_stb_n, 0);
    while (bus_own) @(negedge clk);
    chk(cbr - c0 == 1, "R8 one refresh per grant", cbr - c0, 1);
    chk(!ref_req, "R9 nothing owed after service", ref_req, 0);

    // R8: grant while no request is ignored
    ref_gnt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(col_stb_n == 2'b11 && row_stb_n && !bus_own, "R8 stray grant ignored",
          {bus_own, col_stb_n}, 3);
    end
    ref_gnt = 1'b0;

    // R9: two owed refreshes served back to back
    wait_idx(r + 3 * INTV + 2);
    chk(ref_req && ready, "R9 request with debt queued", ref_req, 1);
    c0 = cbr;
    grant_once();
    while (bus_own) @(negedge clk);
    chk(ref_req, "R9 request re-raised while debt remains", ref_req, 1);
    grant_once();
    while (bus_own) @(negedge clk);
    chk(!ref_req, "R9 debt drained", ref_req, 0);
    chk(cbr - c0 == 2, "R9 refreshes for two owed", cbr - c0, 2);

    // R10: overflow on third due refresh with limit two
    wait_idx(r + 6 * INTV - 1);
    chk(!debt_ovf && ready, "R10 no overflow at limit", debt_ovf, 0);
    @(negedge clk);
    chk(debt_ovf, "R10 overflow flag", debt_ovf, 1);
    chk(!ready, "R10 ready dropped", ready, 0);
    chk(ref_req, "R10 request for re-wake", ref_req, 1);
    repeat (3) @(negedge clk);
    chk(ref_req && col_stb_n == 2'b11, "R10 re-wake waits for grant", ref_req, 1);
    c0 = cbr;
    g = scnt + 1;
    grant_once();
    while (!ready && scnt < g + 1000) @(negedge clk);
    chk(scnt == g + 1 + WAKE * CYC, "R10 ready return edge", scnt, g + 1 + WAKE * CYC);
    chk(cbr - c0 == WAKE, "R10 repeated wake count", cbr - c0, WAKE);
    chk(debt_ovf, "R10 flag sticky", debt_ovf, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule